// File: doc/BRIEF.md
# Supply Startup and Hiccup Sequencer

This block is the digital sequencer of a single-stage offline converter controller. Analog comparators watch the bias supply. They report three things: the supply has climbed past its turn-on level, the supply has sagged under its turn-off level, or the supply has fallen under the level at which logic state is lost. Two further flags arrive from outside: an overload fault and a request to latch the converter off. From these the sequencer drives four controls: the high-voltage startup current source, the gate driver enable, a low-current bias mode, and a one-cycle trigger for the soft-start ramp.

After a fault the converter does not restart straight away. It drains the supply to the turn-off level and recharges it to the turn-on level, and it does this twice. Soft-start fires only on the second return to the turn-on level. A latch request makes this hiccup loop permanent. The loop then repeats between the turn-on and turn-off levels and never reaches the logic-loss level. The only way out is a supply collapse below that level, which happens when power is removed.

All five input flags pass through a two-flop synchronizer before the state machine sees them. Because of this, any output change caused by an input lands on the third rising clock edge after that input changes.

Top module: `supseq_top`

## Requirements
- R1: While reset is asserted, and right after it is released with no supply flag set, the startup source is enabled (1) and the driver enable, low-current enable and soft-start output are all 0.
- R2: In the charging state, a rise of the turn-on flag with no latch pending enables the drivers and disables the startup source. Soft-start is high for exactly one cycle, and that cycle is the first cycle in which the driver enable is high.
- R3: While running, a turn-off flag (undervoltage) disables the drivers, re-enables the startup source and enables low-current mode. This is the recharge half of a hiccup.
- R4: While running, an overload (or a latch request) disables both the drivers and the startup source and enables low-current mode. This is the discharge half of a hiccup.
- R5: In the discharge half, the turn-off flag moves the sequencer to the recharge half: the startup source is 1 and low-current mode stays 1.
- R6: The first time the turn-on flag is reached during hiccup recovery, the sequencer returns to discharge. The drivers stay off and no soft-start pulse is produced.
- R7: The second time the turn-on flag is reached, the drivers are enabled and soft-start pulses. The hiccup count clears on entry to run, so a later fault again needs two recharge cycles.
- R8: A latch request is held internally. Once it is held, every arrival at the turn-on flag returns to discharge, and the drivers never re-enable.
- R9: The logic-loss flag has priority over every other input. It returns the sequencer to the charging state (the R1 outputs) and clears both the held latch and the hiccup count.
- R10: An overload flag has no effect on the outputs while the sequencer is in either half of a hiccup.
- R11: An input change leaves the outputs unchanged after two rising edges and shows at the outputs after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_on_i | input | 1 | Comparator: supply at or above turn-on level |
| sup_below_off_i | input | 1 | Comparator: supply below turn-off level |
| sup_below_rst_i | input | 1 | Comparator: supply below logic-loss level |
| overload_i | input | 1 | Overload fault flag |
| latch_req_i | input | 1 | Request to latch the converter off |
| startup_src_en_o | output | 1 | Enable for the high-voltage startup current source |
| drv_en_o | output | 1 | Gate driver enable |
| low_iq_en_o | output | 1 | Low-current bias mode enable |
| softstart_o | output | 1 | One-cycle soft-start trigger |

## Verification
The bench checks that the first turn-on arrival in hiccup produces no pulse and keeps the drivers off. A design that counted one cycle too few would restart early at that point. It then provokes a second fault right after a restart, to show the hiccup count was cleared. A counter left stale would restart after a single recharge. A latch is held across several full hiccup loops, where a leaky latch would re-enable the drivers. The latch is then cleared by the logic-loss flag, to show that a normal start follows. The bench also samples one edge before the expected response, which catches a synchronizer that is too short or missing.

// File: rtl/supseq_pkg.sv
package supseq_pkg;

    typedef enum logic [1:0] {
        ST_CHARGE = 2'd0,
        ST_RUN    = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_REFILL = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic above_on;
        logic below_off;
        logic below_rst;
        logic overload;
        logic latch_req;
    } flag_s;

    localparam int unsigned FLAG_W = $bits(flag_s);

    typedef struct packed {
        logic src_en;
        logic drv_en;
        logic lowi_en;
    } rail_s;

    function automatic rail_s rail_decode(input seq_state_e s);
        rail_s r;
        unique case (s)
            ST_CHARGE: r = '{src_en: 1'b1, drv_en: 1'b0, lowi_en: 1'b0};
            ST_RUN:    r = '{src_en: 1'b0, drv_en: 1'b1, lowi_en: 1'b0};
            ST_DRAIN:  r = '{src_en: 1'b0, drv_en: 1'b0, lowi_en: 1'b1};
            default:   r = '{src_en: 1'b1, drv_en: 1'b0, lowi_en: 1'b1};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/supseq_sync.sv
module supseq_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supseq_retry_cnt.sv
module supseq_retry_cnt #(
    parameter int unsigned RETRIES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int unsigned CW = (RETRIES < 2) ? 1 : $clog2(RETRIES + 1);
    localparam logic [CW-1:0] LAST = CW'(RETRIES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  cnt_q <= '0;
        else if (inc_i)    cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = (cnt_q == LAST);

    // R7: the count never passes the final retry
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    // R7: increment and clear are never requested together
    p_cnt_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(inc_i && clr_i));
endmodule

// File: rtl/supseq_fsm.sv
module supseq_fsm
    import supseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  flag_s      flg_i,
    input  logic       cnt_last_i,
    output logic       cnt_inc_o,
    output logic       cnt_clr_o,
    output seq_state_e state_o,
    output logic       ss_pulse_o
);
    seq_state_e st_q, st_d;
    logic       lat_q, lat_d;
    logic       ss_q, ss_d;

    always_comb begin
        st_d      = st_q;
        lat_d     = lat_q | flg_i.latch_req;
        ss_d      = 1'b0;
        cnt_inc_o = 1'b0;
        cnt_clr_o = 1'b0;
        if (flg_i.below_rst) begin
            st_d      = ST_CHARGE;
            lat_d     = 1'b0;
            cnt_clr_o = 1'b1;
        end else begin
            unique case (st_q)
                ST_CHARGE: begin
                    if (flg_i.above_on) begin
                        if (lat_d) begin
                            st_d = ST_DRAIN;
                        end else begin
                            st_d      = ST_RUN;
                            ss_d      = 1'b1;
                            cnt_clr_o = 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (flg_i.below_off)                 st_d = ST_REFILL;
                    else if (flg_i.overload || lat_d)    st_d = ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (flg_i.below_off) st_d = ST_REFILL;
                end
                default: begin
                    if (flg_i.above_on) begin
                        if (lat_d) begin
                            st_d = ST_DRAIN;
                        end else if (cnt_last_i) begin
                            st_d      = ST_RUN;
                            ss_d      = 1'b1;
                            cnt_clr_o = 1'b1;
                        end else begin
                            st_d      = ST_DRAIN;
                            cnt_inc_o = 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_CHARGE;
            lat_q <= 1'b0;
            ss_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            lat_q <= lat_d;
            ss_q  <= ss_d;
        end
    end

    assign state_o    = st_q;
    assign ss_pulse_o = ss_q;

    // R2: soft-start lasts one cycle
    p_ss_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        ss_q |=> !ss_q);
    // R3: undervoltage while running leaves run
    p_uv_leaves_run_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && flg_i.below_off && !flg_i.below_rst) |=> st_q == ST_REFILL);
    // R4: overload while running starts a discharge
    p_ovl_drain_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && flg_i.overload && !flg_i.below_off && !flg_i.below_rst)
        |=> st_q == ST_DRAIN);
    // R8: a held latch keeps the drivers off
    p_latch_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (lat_q && st_q != ST_RUN && !flg_i.below_rst) |=> st_q != ST_RUN);
    // R9: logic-loss level clears state and latch
    p_rst_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flg_i.below_rst |=> (st_q == ST_CHARGE && !lat_q));
    // R10: overload alone never moves a hiccup half
    p_ovl_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && !flg_i.below_off && !flg_i.below_rst) |=> st_q == ST_DRAIN);
endmodule

// File: rtl/supseq_top.sv
module supseq_top
    import supseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned RETRIES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_above_on_i,
    input  logic sup_below_off_i,
    input  logic sup_below_rst_i,
    input  logic overload_i,
    input  logic latch_req_i,
    output logic startup_src_en_o,
    output logic drv_en_o,
    output logic low_iq_en_o,
    output logic softstart_o
);
    flag_s      raw_flags, sync_flags;
    seq_state_e state;
    logic       cnt_inc, cnt_clr, cnt_last, ss_pulse;
    rail_s      rails;

    assign raw_flags = '{above_on:  sup_above_on_i,
                         below_off: sup_below_off_i,
                         below_rst: sup_below_rst_i,
                         overload:  overload_i,
                         latch_req: latch_req_i};

    supseq_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (sync_flags)
    );

    supseq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .flg_i      (sync_flags),
        .cnt_last_i (cnt_last),
        .cnt_inc_o  (cnt_inc),
        .cnt_clr_o  (cnt_clr),
        .state_o    (state),
        .ss_pulse_o (ss_pulse)
    );

    supseq_retry_cnt #(.RETRIES(RETRIES)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .last_o (cnt_last)
    );

    assign rails            = rail_decode(state);
    assign startup_src_en_o = rails.src_en;
    assign drv_en_o         = rails.drv_en;
    assign low_iq_en_o      = rails.lowi_en;
    assign softstart_o      = ss_pulse;

    // R2: drivers and startup source never on together
    p_drv_src_excl_r2: assert property (@(posedge clk) disable iff (rst)
        drv_en_o |-> !startup_src_en_o);
    // R2: soft-start only ever coincides with enabled drivers
    p_ss_with_drv_r2: assert property (@(posedge clk) disable iff (rst)
        softstart_o |-> drv_en_o);
    // R5: low-current mode excludes driving
    p_lowi_no_drv_r5: assert property (@(posedge clk) disable iff (rst)
        low_iq_en_o |-> !drv_en_o);
endmodule

// File: tb/supseq_top_test.sv
`timescale 1ns/1ps
module supseq_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_on = 1'b0, b_off = 1'b0, b_rst = 1'b1, ovl = 1'b0, lrq = 1'b0;
    logic src, drv, lowi, ss;

    always #2 clk = ~clk;

    supseq_top uut (
        .clk (clk), .rst (rst),
        .sup_above_on_i (a_on), .sup_below_off_i (b_off), .sup_below_rst_i (b_rst),
        .overload_i (ovl), .latch_req_i (lrq),
        .startup_src_en_o (src), .drv_en_o (drv), .low_iq_en_o (lowi), .softstart_o (ss)
    );

    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // expected output bundles {src, drv, lowi, ss}
    localparam logic [3:0] O_CHARGE = 4'b1000;
    localparam logic [3:0] O_START  = 4'b0101;
    localparam logic [3:0] O_RUN    = 4'b0100;
    localparam logic [3:0] O_DRAIN  = 4'b0010;
    localparam logic [3:0] O_REFILL = 4'b1010;

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if ({src, drv, lowi, ss} !== e.v) begin
                n_bad++;
                $display("FAIL %s: actual src/drv/lowi/ss=%b expected %b",
                         e.tag, {src, drv, lowi, ss}, e.v);
            end
        end
    end

    task automatic drive(input logic on_f, off_f, rst_f, ovl_f, lrq_f);
        @(negedge clk);
        a_on = on_f; b_off = off_f; b_rst = rst_f; ovl = ovl_f; lrq = lrq_f;
    endtask

    task automatic expect_after(input int edges, input logic [3:0] v, input string tag);
        exp_t e;
        repeat (edges) @(posedge clk);
        e.v = v; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        expect_after(0, O_CHARGE, "R1 in reset");
        @(negedge clk); rst = 1'b0;
        expect_after(1, O_CHARGE, "R1 after reset");

        drive(0, 1, 0, 0, 0);
        expect_after(3, O_CHARGE, "R1 charging below off");
        drive(0, 0, 0, 0, 0);
        expect_after(3, O_CHARGE, "R1 charging between levels");

        // normal turn-on, latency probe
        drive(1, 0, 0, 0, 0);
        expect_after(2, O_CHARGE, "R11 no change after two edges");
        expect_after(1, O_START,  "R2 turn-on with soft-start");
        expect_after(1, O_RUN,    "R2 soft-start lasts one cycle");

        // overload fault
        drive(1, 0, 0, 1, 0);
        expect_after(3, O_DRAIN, "R4 overload starts discharge");
        drive(0, 0, 0, 1, 0);
        expect_after(3, O_DRAIN, "R10 overload ignored in discharge");
        drive(0, 1, 0, 1, 0);
        expect_after(3, O_REFILL, "R5 turn-off starts recharge");
        expect_after(2, O_REFILL, "R10 overload ignored in recharge");
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_DRAIN, "R6 first turn-on returns to discharge");
        expect_after(1, O_DRAIN, "R6 no soft-start on first turn-on");
        drive(0, 1, 0, 0, 0);
        expect_after(3, O_REFILL, "R5 second recharge");
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_START, "R7 second turn-on restarts");
        expect_after(1, O_RUN,   "R7 running after restart");

        // undervoltage fault, counter must be clear again
        drive(0, 1, 0, 0, 0);
        expect_after(3, O_REFILL, "R3 undervoltage stops drivers");
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_DRAIN, "R7 count cleared, first turn-on again");
        drive(0, 1, 0, 0, 0);
        expect_after(3, O_REFILL, "R5 recharge after undervoltage");
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_START, "R7 restart after undervoltage");
        expect_after(1, O_RUN,   "R7 run after undervoltage");

        // latched fault
        drive(1, 0, 0, 0, 1);
        expect_after(3, O_DRAIN, "R8 latch request stops drivers");
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_DRAIN, "R8 latch held after request drops");
        for (int k = 0; k < 3; k++) begin
            drive(0, 1, 0, 0, 0);
            expect_after(3, O_REFILL, "R8 latched recharge");
            drive(1, 0, 0, 0, 0);
            expect_after(3, O_DRAIN, "R8 latched turn-on stays off");
            expect_after(1, O_DRAIN, "R8 latched no soft-start");
        end

        // logic-loss clears the latch
        drive(0, 1, 1, 0, 0);
        expect_after(3, O_CHARGE, "R9 logic-loss returns to charging");
        drive(0, 1, 1, 1, 1);
        expect_after(3, O_CHARGE, "R9 logic-loss overrides other flags");
        drive(0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0);
        expect_after(3, O_START, "R9 latch cleared, normal start");
        expect_after(1, O_RUN,   "R9 running after clear");

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule